// File: doc/BRIEF.md
# Stream-to-Register-Bus Request Bridge

This block sits between a packet stream and a simple on-chip register bus. Request packets come in on a 32-bit valid/ready/last stream. Each packet is turned into a run of register-bus reads or writes, and a reply packet goes out on a second 32-bit valid/ready/last stream. Word 0 of a request is a packed header. It holds a message type, a 13-bit sequence number and, for reads, a 7-bit word count. Word 1 is the start address. A write request carries its data words after that.

A running sequence count is compared with every request before any bus access is made. If the numbers do not match, the request is consumed without touching the bus and a refusal reply is sent. Addresses step up by one for each data word.

On the input stream a word moves on a rising clock edge where both `s_valid` and `s_ready` are high. `s_ready` depends only on the bridge's internal state, never on `s_valid`, and the source may leave gaps of any length. On the output stream, once `m_valid` is high it stays high with the same `m_data` and `m_last` until a cycle in which `m_ready` is high. The bus takes a write in the cycle `bus_wen` is high. A read is requested by a one-cycle `bus_ren` pulse. It is answered by `bus_rvalid` with `bus_rdata` one or more cycles later, and only one read is outstanding at a time.

Top module: `stream_regbus_bridge`

## Requirements
- R1: An input word is taken only on an edge where `s_valid` and `s_ready` are both high; idle gaps in `s_valid` inside a packet never lose or duplicate a word.
- R2: The header layout is: type in bits [2:0] (1 = read request, 2 = write request), sequence number in bits [15:3], read word count in bits [22:16]; the word after the header is the start address.
- R3: The expected sequence number is 0 after reset and advances by one, modulo 8192, after each accepted read or write request.
- R4: A read or write request whose sequence number differs from the expected one causes no bus access. It is consumed up to `s_last` and answered by one word with type 5 in bits [2:0], the expected sequence number in bits [15:3], zero elsewhere, and `m_last` high.
- R5: Each data word of an accepted write request produces one `bus_wen` cycle. The first goes to the start address and each later one to the next address up.
- R6: An accepted write request is answered by one word with type 4 in bits [2:0], the request's sequence number in bits [15:3], zero elsewhere, and `m_last` high.
- R7: An accepted read request is answered by a header with type 3 in bits [2:0], the sequence number in [15:3] and the word count in [22:16]. The requested words follow in order from the start address. `m_last` is high on the final word, or on the header itself when the count is 0.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold their values.
- R9: A packet whose header word carries `s_last` is dropped: no bus access, no reply, and the sequence count is unchanged.
- R10: A packet with a type other than 1 or 2 is consumed with no bus access, no reply and no change to the sequence count.
- R11: Words that follow the address in a read request are consumed and ignored; the reply is the same as for a read request without them.
- R12: During and right after reset, `m_valid`, `bus_wen` and `bus_ren` are low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_data | input | 32 | Request stream word |
| s_valid | input | 1 | Request word present |
| s_last | input | 1 | Final word of request packet |
| s_ready | output | 1 | Bridge accepts a request word |
| m_data | output | 32 | Reply stream word |
| m_valid | output | 1 | Reply word present |
| m_last | output | 1 | Final word of reply packet |
| m_ready | input | 1 | Sink accepts a reply word |
| bus_addr | output | ADDR_W | Register bus address |
| bus_wdata | output | 32 | Register bus write data |
| bus_wen | output | 1 | Write strobe, one cycle per word |
| bus_ren | output | 1 | Read request pulse |
| bus_rdata | input | 32 | Read data |
| bus_rvalid | input | 1 | Read data valid |

## Verification
The bench builds the bridge with its default 32-bit bus address. Field widths are fixed: 13 sequence bits and 7 count bits. With those widths the bench can send 8192 back-to-back requests and walk the sequence count through its wrap from 8191 to 0. It can also issue a read of the largest count, 127 words. A read of zero words, stalled reply sinks and gapped request sources are all run against the same width settings.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int WORD_W  = 32;
  localparam int TYPE_W  = 3;
  localparam int SEQ_W   = 13;
  localparam int LEN_W   = 7;
  localparam int SEQ_LSB = TYPE_W;
  localparam int LEN_LSB = 16;

  typedef logic [TYPE_W-1:0] msg_t;

  localparam msg_t MT_RD_REQ = 3'd1;
  localparam msg_t MT_WR_REQ = 3'd2;
  localparam msg_t MT_RD_RSP = 3'd3;
  localparam msg_t MT_WR_ACK = 3'd4;
  localparam msg_t MT_NACK   = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_WDATA,
    S_DRAIN,
    S_REPLY,
    S_RHDR,
    S_RREQ,
    S_RWAIT
  } st_e;

  function automatic logic [WORD_W-1:0] pack_hdr(input msg_t t,
                                                 input logic [SEQ_W-1:0] s,
                                                 input logic [LEN_W-1:0] n);
    logic [WORD_W-1:0] w;
    w = '0;
    w[TYPE_W-1:0]       = t;
    w[SEQ_LSB +: SEQ_W] = s;
    w[LEN_LSB +: LEN_W] = n;
    return w;
  endfunction
endpackage

// File: rtl/sbr_hdr_decode.sv
module sbr_hdr_decode
  import sbr_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [SEQ_W-1:0]  seq,
  output logic [LEN_W-1:0]  count,
  output logic              is_read,
  output logic              is_write
);
  msg_t kind;
  logic unused_hi;

  assign kind      = word[TYPE_W-1:0];
  assign seq       = word[SEQ_LSB +: SEQ_W];
  assign count     = word[LEN_LSB +: LEN_W];
  assign is_read   = (kind == MT_RD_REQ);
  assign is_write  = (kind == MT_WR_REQ);
  assign unused_hi = ^word[WORD_W-1:LEN_LSB+LEN_W];
endmodule

// File: rtl/sbr_seq_track.sv
module sbr_seq_track #(
  parameter int SW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [SW-1:0] expected
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       expected <= '0;
    else if (advance) expected <= expected + 1'b1;
  end

  // R3: one step per accepted request, wrapping at the field width
  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> expected == SW'($past(expected) + 1'b1));
endmodule

// File: rtl/sbr_tx_slot.sv
module sbr_tx_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ldata,
  input  logic         llast,
  output logic         free,
  output logic         empty,
  output logic         m_valid,
  output logic [W-1:0] m_data,
  output logic         m_last,
  input  logic         m_ready
);
  assign free  = !m_valid || m_ready;
  assign empty = !m_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_last  <= 1'b0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= ldata;
      m_last  <= llast;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R8: a stalled word is held unchanged
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
  // R8: the controller never overwrites a word the sink has not taken
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> free);
endmodule

// File: rtl/sbr_bus_port.sv
module sbr_bus_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  logic          rd_go,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wen,
  output logic          bus_ren
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_wen   <= 1'b0;
      bus_ren   <= 1'b0;
    end else begin
      bus_wen <= wr_go;
      bus_ren <= rd_go;
      if (wr_go || rd_go) bus_addr <= addr_in;
      if (wr_go)          bus_wdata <= wdata_in;
    end
  end

  // R5: a cycle is either a write or a read, never both
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wen && bus_ren));
  // R7: read pulses never run back to back (one outstanding read)
  a_r7_read_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ren |=> !bus_ren);
endmodule

// File: rtl/stream_regbus_bridge.sv
module stream_regbus_bridge
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic [WORD_W-1:0] m_data,
  output logic              m_valid,
  output logic              m_last,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  output logic              bus_wen,
  output logic              bus_ren,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_rvalid
);
  localparam logic [LEN_W-1:0] ONE_LEFT = LEN_W'(1);

  st_e st_q, st_d, after_q, after_d;

  logic [SEQ_W-1:0]  dec_seq;
  logic [LEN_W-1:0]  dec_len;
  logic              dec_rd, dec_wr;

  logic [SEQ_W-1:0]  seq_q;
  logic [LEN_W-1:0]  len_q, remain_q;
  logic              rd_q, wr_q, nack_q, nack_d;
  logic [ADDR_W-1:0] addr_q;

  logic [SEQ_W-1:0]  exp_seq;
  logic              seq_adv;
  logic              in_hs, wr_go, rd_go;
  logic              tx_load, tx_end, tx_free, tx_empty;
  logic [WORD_W-1:0] tx_word;

  sbr_hdr_decode u_dec (
    .word     (s_data),
    .seq      (dec_seq),
    .count    (dec_len),
    .is_read  (dec_rd),
    .is_write (dec_wr)
  );

  sbr_seq_track #(.SW(SEQ_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (seq_adv),
    .expected (exp_seq)
  );

  sbr_tx_slot #(.W(WORD_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tx_load),
    .ldata   (tx_word),
    .llast   (tx_end),
    .free    (tx_free),
    .empty   (tx_empty),
    .m_valid (m_valid),
    .m_data  (m_data),
    .m_last  (m_last),
    .m_ready (m_ready)
  );

  sbr_bus_port #(.AW(ADDR_W), .DW(WORD_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_go     (wr_go),
    .rd_go     (rd_go),
    .addr_in   (addr_q),
    .wdata_in  (s_data),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wen   (bus_wen),
    .bus_ren   (bus_ren)
  );

  // Input is taken only in states that consume request words.
  assign s_ready = (st_q == S_IDLE) || (st_q == S_ADDR) ||
                   (st_q == S_WDATA) || (st_q == S_DRAIN);
  assign in_hs   = s_valid && s_ready;

  always_comb begin
    st_d    = st_q;
    after_d = after_q;
    nack_d  = nack_q;
    seq_adv = 1'b0;
    wr_go   = 1'b0;
    rd_go   = 1'b0;
    tx_load = 1'b0;
    tx_word = '0;
    tx_end  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (in_hs && !s_last) st_d = S_ADDR;
      end
      S_ADDR: begin
        if (in_hs) begin
          if (!(rd_q || wr_q)) begin
            st_d    = s_last ? S_IDLE : S_DRAIN;
            after_d = S_IDLE;
          end else if (seq_q != exp_seq) begin
            nack_d  = 1'b1;
            st_d    = s_last ? S_REPLY : S_DRAIN;
            after_d = S_REPLY;
          end else begin
            nack_d  = 1'b0;
            seq_adv = 1'b1;
            if (wr_q) begin
              st_d = s_last ? S_REPLY : S_WDATA;
            end else begin
              st_d    = s_last ? S_RHDR : S_DRAIN;
              after_d = S_RHDR;
            end
          end
        end
      end
      S_WDATA: begin
        if (in_hs) begin
          wr_go = 1'b1;
          if (s_last) st_d = S_REPLY;
        end
      end
      S_DRAIN: begin
        if (in_hs && s_last) st_d = after_q;
      end
      S_REPLY: begin
        if (tx_free) begin
          tx_load = 1'b1;
          tx_end  = 1'b1;
          tx_word = nack_q ? pack_hdr(MT_NACK, exp_seq, '0)
                           : pack_hdr(MT_WR_ACK, seq_q, '0);
          st_d    = S_IDLE;
        end
      end
      S_RHDR: begin
        if (tx_free) begin
          tx_load = 1'b1;
          tx_word = pack_hdr(MT_RD_RSP, seq_q, len_q);
          tx_end  = (remain_q == '0);
          st_d    = (remain_q == '0) ? S_IDLE : S_RREQ;
        end
      end
      S_RREQ: begin
        if (tx_empty) begin
          rd_go = 1'b1;
          st_d  = S_RWAIT;
        end
      end
      S_RWAIT: begin
        if (bus_rvalid) begin
          tx_load = 1'b1;
          tx_word = bus_rdata;
          tx_end  = (remain_q == ONE_LEFT);
          st_d    = (remain_q == ONE_LEFT) ? S_IDLE : S_RREQ;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      after_q  <= S_IDLE;
      nack_q   <= 1'b0;
      seq_q    <= '0;
      len_q    <= '0;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      remain_q <= '0;
    end else begin
      st_q    <= st_d;
      after_q <= after_d;
      nack_q  <= nack_d;
      if (st_q == S_IDLE && in_hs) begin
        seq_q <= dec_seq;
        len_q <= dec_len;
        rd_q  <= dec_rd;
        wr_q  <= dec_wr;
      end
      if (st_q == S_ADDR && in_hs) begin
        addr_q   <= s_data[ADDR_W-1:0];
        remain_q <= len_q;
      end else if (wr_go || rd_go) begin
        addr_q <= addr_q + 1'b1;
      end
      if (st_q == S_RWAIT && bus_rvalid) remain_q <= remain_q - 1'b1;
    end
  end

  // R4: while a refused or surplus tail is consumed, the bus stays quiet
  a_r4_drain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DRAIN) |-> (!bus_wen && !bus_ren));
  // R9: a header that ends its packet leaves the bridge waiting for a new header
  a_r9_short_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && s_valid && s_ready && s_last) |=> (s_ready && !m_valid && !bus_wen));
endmodule

// File: tb/stream_regbus_bridge_test.sv
module stream_regbus_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_valid = 1'b0, s_last = 1'b0, s_ready;
  logic [31:0] m_data;
  logic        m_valid, m_last;
  logic        m_ready = 1'b1;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_wen, bus_ren;
  logic [31:0] bus_rdata = '0;
  logic        bus_rvalid = 1'b0;

  always #4 clk = ~clk;

  stream_regbus_bridge uut (
    .clk(clk), .rst_n(rst_n),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .m_data(m_data), .m_valid(m_valid), .m_last(m_last), .m_ready(m_ready),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit stall_mode = 0;
  string ctx_tag = "R12";

  // model state
  int          exp_seq = 0;
  logic [31:0] mmem [256];
  logic [31:0] smem [256];
  logic [32:0] oq[$];
  string       otag[$];
  logic [63:0] wq[$];
  logic [31:0] rq[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(int t, int s, int n);
    return 32'(t & 7) | (32'(s & 8191) << 3) | (32'(n & 127) << 16);
  endfunction

  // reference model plus stimulus for one request packet
  task automatic request(input int typ, input int seq, input int len, input logic [31:0] addr,
                         input int ndata, input bit hdr_only, input bit gaps);
    logic [32:0] w[$];
    logic [31:0] d;
    w.push_back({hdr_only, hdr(typ, seq, len)});
    if (!hdr_only) begin
      w.push_back({ndata == 0, addr});
      for (int i = 0; i < ndata; i++) begin
        d = $urandom;
        w.push_back({i == ndata - 1, d});
      end
    end
    if (hdr_only || !(typ == 1 || typ == 2)) begin
      // R9 / R10: nothing expected
    end else if (seq != exp_seq) begin
      oq.push_back({1'b1, hdr(5, exp_seq, 0)}); otag.push_back("R4");
    end else begin
      exp_seq = (exp_seq + 1) % 8192;
      if (typ == 2) begin
        for (int i = 0; i < ndata; i++) begin
          logic [31:0] a;
          a = addr + 32'(i);
          wq.push_back({a, w[i+2][31:0]});
          mmem[a[7:0]] = w[i+2][31:0];
        end
        oq.push_back({1'b1, hdr(4, seq, 0)}); otag.push_back("R6");
      end else begin
        oq.push_back({len == 0, hdr(3, seq, len)}); otag.push_back("R7");
        for (int i = 0; i < len; i++) begin
          logic [31:0] a;
          a = addr + 32'(i);
          rq.push_back(a);
          oq.push_back({i == len - 1, mmem[a[7:0]]});
          otag.push_back(ndata > 0 ? "R11" : "R7");
        end
      end
    end
    send_words(w, gaps);
  endtask

  task automatic send_words(input logic [32:0] w[$], input bit gaps);
    bit hs;
    @(negedge clk);
    foreach (w[i]) begin
      if (gaps && ($urandom % 2 == 1)) begin
        s_valid = 1'b0;
        repeat (1 + $urandom % 4) @(negedge clk);
      end
      s_valid = 1'b1;
      s_data  = w[i][31:0];
      s_last  = w[i][32];
      forever begin
        hs = s_ready;
        @(negedge clk);
        if (hs) break;
      end
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic wait_idle(input int pad);
    while (oq.size() != 0 || wq.size() != 0 || rq.size() != 0) @(negedge clk);
    repeat (pad) @(negedge clk);
  endtask

  // monitor and bus slave, all at the falling edge
  logic        pv = 0, pr = 0, pl = 0;
  logic [31:0] pd = 0;
  bit          rd_pend = 0;
  logic [31:0] rd_addr = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr)
        chk(m_valid && m_data == pd && m_last == pl, "R8", {31'd0, m_valid, m_data}, {31'd1, pd});
      m_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
      if (m_valid && m_ready) begin
        if (oq.size() == 0) chk(0, ctx_tag, {31'd0, m_last, m_data}, 64'hDEAD);
        else begin
          logic [32:0] e;
          string t;
          e = oq.pop_front();
          t = otag.pop_front();
          chk({m_last, m_data} == e, t, {31'd0, m_last, m_data}, {31'd0, e});
        end
      end
      pv = m_valid; pr = m_ready; pd = m_data; pl = m_last;

      if (rd_pend) begin
        bus_rvalid = 1'b1;
        bus_rdata  = smem[rd_addr[7:0]];
        rd_pend    = 0;
      end else begin
        bus_rvalid = 1'b0;
      end
      if (bus_wen) begin
        smem[bus_addr[7:0]] = bus_wdata;
        if (wq.size() == 0) chk(0, ctx_tag, {bus_addr, bus_wdata}, 64'hDEAD);
        else begin
          logic [63:0] e;
          e = wq.pop_front();
          chk({bus_addr, bus_wdata} == e, "R5", {bus_addr, bus_wdata}, e);
        end
      end
      if (bus_ren) begin
        rd_pend = 1;
        rd_addr = bus_addr;
        if (rq.size() == 0) chk(0, ctx_tag, {32'd0, bus_addr}, 64'hDEAD);
        else begin
          logic [31:0] e;
          e = rq.pop_front();
          chk(bus_addr == e, "R7", {32'd0, bus_addr}, {32'd0, e});
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mmem[i] = 32'hC3A5_0000 ^ (32'(i) * 32'h0101_0107);
      smem[i] = mmem[i];
    end
    repeat (3) @(negedge clk);
    chk(!m_valid && !bus_wen && !bus_ren, "R12", {m_valid, bus_wen, bus_ren}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_valid && !bus_wen && !bus_ren && s_ready, "R12",
        {m_valid, bus_wen, bus_ren, s_ready}, 64'd1);

    ctx_tag = "R5";
    request(2, 0, 0, 32'h1234_5610, 3, 0, 1);            // R1 R5 R6 gapped write
    wait_idle(3);
    ctx_tag = "R7";
    stall_mode = 1;
    request(1, 1, 3, 32'h1234_5610, 0, 0, 0);            // R7 R8 read back
    wait_idle(3);
    request(1, 2, 0, 32'h0000_0040, 0, 0, 0);            // R7 zero-length read
    wait_idle(3);
    stall_mode = 0;
    ctx_tag = "R4";
    request(2, 7, 0, 32'h0000_0020, 4, 0, 1);            // R4 bad seq write
    wait_idle(3);
    request(1, 0, 2, 32'h0000_0020, 0, 0, 0);            // R4 bad seq read
    wait_idle(3);
    ctx_tag = "R9";
    request(2, 3, 0, 32'h0, 0, 1, 0);                    // R9 header only
    wait_idle(6);
    ctx_tag = "R10";
    request(6, 3, 2, 32'h0000_0030, 3, 0, 1);            // R10 unknown type
    wait_idle(6);
    ctx_tag = "R2";
    request(2, 3, 0, 32'h0000_0050, 0, 0, 0);            // R2 R3 seq unchanged, empty write
    wait_idle(3);
    ctx_tag = "R11";
    request(1, 4, 2, 32'h1234_5610, 2, 0, 1);            // R11 read with surplus words
    wait_idle(3);
    ctx_tag = "R7";
    request(1, 5, 127, 32'h0000_0080, 0, 0, 0);          // R7 largest count
    wait_idle(3);

    ctx_tag = "R1";
    stall_mode = 1;
    for (int k = 0; k < 40; k++) begin
      int t, s;
      t = ($urandom % 5 == 0) ? 1 : (($urandom % 2 == 1) ? 1 : 2);
      s = ($urandom % 4 == 0) ? (exp_seq + 1) % 8192 : exp_seq;
      request(t, s, $urandom % 6, 32'($urandom % 250), $urandom % 4, 0, 1);
      wait_idle(2);
    end
    stall_mode = 0;

    ctx_tag = "R3";
    for (int k = 0; k < 8192; k++) begin                 // R3 wrap through 8191 -> 0
      request(2, exp_seq, 0, 32'h0000_0010, 0, 0, 0);
      wait_idle(0);
    end
    request(2, (exp_seq + 8191) % 8192, 0, 32'h10, 0, 0, 0);  // R3 stale number refused
    wait_idle(2);
    request(2, exp_seq, 1, 32'h0000_0011, 1, 0, 0);      // R3 after wrap
    wait_idle(4);
    finish_run();
  end
endmodule